// File: doc/BRIEF.md
# Cascadable Presettable Decade/Binary Counter

This block is a synchronous up-counter with a parallel preset. A compile-time flag selects its modulus: ten, counting 0 to 9, or sixteen, counting 0 to 15. A second flag selects how the active-low clear works. It can act at once, without waiting for the clock, or only at a rising clock edge. On every rising edge the counter performs exactly one of four actions: clear, load, count or hold.

Counting needs two enables. One is a parallel enable that is shared by every stage. The other is a trickle enable, and only the trickle enable takes part in the terminal-count flag. The flag is high while the counter sits at its top value and the trickle enable is high. Wiring each stage's flag into the next stage's trickle enable builds a multi-digit counter with no extra gates. Because the flag is combinational, that chain settles within the same cycle.

In decimal mode a preset can load a code from 10 to 15. Such a code never raises the flag, and counting leaves it along a fixed path that reaches 0 within two counting edges.

Top module: `bcd_bin_counter`

## Requirements
- R1: With `load_n` high and both `en_par` and `en_trk` high, each rising edge adds one to `q`. From the top value (9 in decimal mode, 15 in binary mode) the next count gives 0.
- R2: With `ASYNC_CLEAR`=1, a low `rst_n` forces `q` to 0 at once, with no clock edge, and overrides every other input.
- R3: With `ASYNC_CLEAR`=0, a low `rst_n` leaves `q` unchanged until the next rising edge. That edge sets `q` to 0, whatever `load_n`, `en_par` and `en_trk` are.
- R4: When clear is inactive and `load_n` is low, a rising edge copies `din` into `q`, whatever the two enables are.
- R5: When clear is inactive, `load_n` is high and either `en_par` or `en_trk` is low, a rising edge leaves `q` unchanged.
- R6: `tc` is high exactly when `en_trk` is high and `q` holds the top value (4'b1001 in decimal mode, 4'b1111 in binary mode). It does not depend on `en_par` or `load_n`, and it follows `en_trk` in the same cycle.
- R7: In decimal mode, `q` values 10 to 15 never raise `tc`.
- R8: In decimal mode, a counting edge takes 10 to 11, 12 to 13 and 14 to 15, and takes 11, 13 and 15 to 0. Any code from 10 to 15 therefore reaches the range 0 to 9 within two counting edges.
- R9: Two decimal stages can be chained as follows. The low stage's `en_trk` is tied high. The low stage's `tc` drives the high stage's `en_trk`. Both stages share `en_par`. Chained this way, the pair counts 00 to 99 and wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all changes on the rising edge except the immediate clear |
| rst_n | input | 1 | Active-low clear; immediate or edge-sampled according to `ASYNC_CLEAR` |
| load_n | input | 1 | Active-low preset strobe |
| din | input | DW | Preset value |
| en_par | input | 1 | Count enable shared by all stages; has no part in `tc` |
| en_trk | input | 1 | Count enable that also gates `tc`; used as the carry input in a chain |
| q | output | DW | Counter state |
| tc | output | 1 | Terminal count: `en_trk` AND (`q` equals the top value) |

Actions: ACT_CLEAR, ACT_LOAD, ACT_COUNT and ACT_HOLD, chosen by priority in that order. Transitions: any state to 0 (clear), any state to `din` (load), state to state+1 or to 0 (count, including the decimal illegal-code map), and state to itself (hold).

## Verification
A wrong next value shows on `q` one edge after the action that caused it. The bench compares `q` after every edge. A bad wrap or a bad illegal-code path also shows on `tc` in the following cycle, and in a chain it shows as a wrong tens digit on the same edge. A wrong immediate clear shows on `q` within the same cycle, before any edge. A wrong terminal-count decode shows on `tc` as soon as `en_trk` or `q` changes, so the bench samples it between edges.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // One action is taken on each rising edge; the order of the
    // encodings has no meaning, priority lives in the decoder.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } ctr_act_e;

endpackage

// File: rtl/ctr_action_decode.sv
module ctr_action_decode
    import ctr_pkg::*;
(
    input  logic     clr_req,
    input  logic     load_n,
    input  logic     en_par,
    input  logic     en_trk,
    output ctr_act_e act
);

    logic cnt_ok;

    assign cnt_ok = en_par & en_trk;

    // Priority: clear, then load, then count, else hold.
    always_comb begin
        unique casez ({clr_req, ~load_n, cnt_ok})
            3'b1??:  act = ACT_CLEAR;
            3'b01?:  act = ACT_LOAD;
            3'b001:  act = ACT_COUNT;
            default: act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/ctr_next_value.sv
module ctr_next_value
    import ctr_pkg::*;
#(
    parameter bit DECIMAL = 1'b1,
    parameter int DW      = 4
) (
    input  ctr_act_e        act,
    input  logic [DW-1:0]   cur,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   nxt
);

    localparam logic [DW-1:0] ONE     = DW'(1);
    localparam logic [DW-1:0] MAX_VAL = DECIMAL ? DW'(9) : {DW{1'b1}};

    logic [DW-1:0] inc_val;

    generate
        if (DECIMAL) begin : g_dec
            // Codes above the top value step in pairs back to zero:
            // an even illegal code moves to its odd neighbour, an odd one to 0.
            always_comb begin
                if (cur == MAX_VAL) begin
                    inc_val = '0;
                end else if (cur > MAX_VAL) begin
                    inc_val = cur[0] ? '0 : cur + ONE;
                end else begin
                    inc_val = cur + ONE;
                end
            end
        end else begin : g_bin
            // Full-range binary: natural overflow gives the wrap.
            assign inc_val = cur + ONE;
        end
    endgenerate

    always_comb begin
        unique case (act)
            ACT_CLEAR: nxt = '0;
            ACT_LOAD:  nxt = din;
            ACT_COUNT: nxt = inc_val;
            ACT_HOLD:  nxt = cur;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/ctr_terminal_detect.sv
module ctr_terminal_detect #(
    parameter bit DECIMAL = 1'b1,
    parameter int DW      = 4
) (
    input  logic [DW-1:0] cur,
    input  logic          en_trk,
    output logic          tc
);

    localparam logic [DW-1:0] MAX_VAL = DECIMAL ? DW'(9) : {DW{1'b1}};

    logic at_top;

    // Full decode: a single state matches.
    assign at_top = (cur == MAX_VAL);
    assign tc     = en_trk & at_top;

endmodule

// File: rtl/bcd_bin_counter.sv
module bcd_bin_counter
    import ctr_pkg::*;
#(
    parameter bit DECIMAL     = 1'b1,
    parameter bit ASYNC_CLEAR = 1'b0,
    parameter int DW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_n,
    input  logic [DW-1:0] din,
    input  logic          en_par,
    input  logic          en_trk,
    output logic [DW-1:0] q,
    output logic          tc
);

    ctr_act_e      act;
    logic          clr_req;
    logic [DW-1:0] q_r;
    logic [DW-1:0] q_nxt;

    ctr_action_decode u_dec (
        .clr_req (clr_req),
        .load_n  (load_n),
        .en_par  (en_par),
        .en_trk  (en_trk),
        .act     (act)
    );

    ctr_next_value #(
        .DECIMAL (DECIMAL),
        .DW      (DW)
    ) u_nxt (
        .act (act),
        .cur (q_r),
        .din (din),
        .nxt (q_nxt)
    );

    ctr_terminal_detect #(
        .DECIMAL (DECIMAL),
        .DW      (DW)
    ) u_term (
        .cur    (q_r),
        .en_trk (en_trk),
        .tc     (tc)
    );

    // State register: the clear style picks the register template.
    generate
        if (ASYNC_CLEAR) begin : g_async
            assign clr_req = 1'b0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_r <= '0;
                end else begin
                    q_r <= q_nxt;
                end
            end
        end else begin : g_sync
            assign clr_req = ~rst_n;
            always_ff @(posedge clk) begin
                q_r <= q_nxt;
            end
        end
    endgenerate

    // Outputs
    assign q = q_r;

endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
    parameter bit DECIMAL     = 1'b1,
    parameter bit ASYNC_CLEAR = 1'b0,
    parameter int DW          = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_n,
    input logic [DW-1:0] din,
    input logic          en_par,
    input logic          en_trk,
    input logic [DW-1:0] q,
    input logic          tc
);

    localparam logic [DW-1:0] MAX_VAL = DECIMAL ? DW'(9) : {DW{1'b1}};
    localparam logic [DW-1:0] ONE     = DW'(1);

    logic counting;
    assign counting = load_n & en_par & en_trk;

    generate
        if (ASYNC_CLEAR) begin : g_ac
            AST_CLEAR_IMMEDIATE: assert property (@(posedge clk)
                !rst_n |-> q == '0);  // R2
        end else begin : g_sc
            AST_CLEAR_AT_EDGE: assert property (@(posedge clk)
                !rst_n |=> q == '0);  // R3
        end
    endgenerate

    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din));  // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_par && en_trk)) |=> $stable(q));  // R5

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && q == MAX_VAL) |=> q == '0);  // R1

    AST_TC_ONLY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> q == MAX_VAL);  // R6

    AST_TC_NEEDS_TRICKLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_trk |-> !tc);  // R6

    generate
        if (DECIMAL) begin : g_dchk
            AST_NO_TC_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
                (q > MAX_VAL) |-> !tc);  // R7

            AST_ILLEGAL_ODD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
                (counting && q > MAX_VAL && q[0]) |=> q == '0);  // R8

            AST_ILLEGAL_EVEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (counting && q > MAX_VAL && !q[0]) |=> q == ($past(q) + ONE));  // R8
        end
    endgenerate

endmodule

bind bcd_bin_counter ctr_checker #(
    .DECIMAL     (DECIMAL),
    .ASYNC_CLEAR (ASYNC_CLEAR),
    .DW          (DW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .din    (din),
    .en_par (en_par),
    .en_trk (en_trk),
    .q      (q),
    .tc     (tc)
);

// File: tb/bcd_bin_counter_tb.sv
module bcd_bin_counter_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    // Group A: shared stimulus for a decimal/edge-clear and a binary/immediate-clear unit
    logic       rst_n, load_n, en_par, en_trk;
    logic [3:0] din;
    logic [3:0] q_a, q_b;
    logic       tc_a, tc_b;

    // Group C: two-digit chain
    logic       c_rst_n, c_en;
    logic [3:0] q_lo, q_hi;
    logic       tc_lo, tc_hi;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [3:0] ea, eb;

    bcd_bin_counter #(.DECIMAL(1'b1), .ASYNC_CLEAR(1'b0), .DW(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .q(q_a), .tc(tc_a));

    bcd_bin_counter #(.DECIMAL(1'b0), .ASYNC_CLEAR(1'b1), .DW(4)) u_bin (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .q(q_b), .tc(tc_b));

    bcd_bin_counter #(.DECIMAL(1'b1), .ASYNC_CLEAR(1'b1), .DW(4)) u_lo (
        .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din(4'd0),
        .en_par(c_en), .en_trk(1'b1), .q(q_lo), .tc(tc_lo));

    bcd_bin_counter #(.DECIMAL(1'b1), .ASYNC_CLEAR(1'b1), .DW(4)) u_hi (
        .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din(4'd0),
        .en_par(c_en), .en_trk(tc_lo), .q(q_hi), .tc(tc_hi));

    // Expected next state, from the requirements
    function automatic logic [3:0] model(bit dec, logic [3:0] cur, bit clr, bit ld,
                                         logic [3:0] d, bit ep, bit et);
        if (clr)            return 4'd0;
        if (ld)             return d;
        if (!(ep && et))    return cur;
        if (!dec)           return cur + 4'd1;
        if (cur == 4'd9)    return 4'd0;
        if (cur > 4'd9)     return cur[0] ? 4'd0 : cur + 4'd1;
        return cur + 4'd1;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(bit r, bit l, bit p, bit t, logic [3:0] d);
        @(negedge clk);
        rst_n = r; load_n = l; en_par = p; en_trk = t; din = d;
    endtask

    task automatic tick(string req);
        logic [3:0] na, nb;
        na = model(1'b1, ea, !rst_n, !load_n, din, en_par, en_trk);
        nb = model(1'b0, eb, !rst_n, !load_n, din, en_par, en_trk);
        @(posedge clk);
        #2;
        ea = na;
        eb = nb;
        check(req, "q_a", int'(q_a), int'(ea));
        check(req, "q_b", int'(q_b), int'(eb));
        check("R6", "tc_a", int'(tc_a), int'(en_trk && ea == 4'd9));
        check("R6", "tc_b", int'(tc_b), int'(en_trk && eb == 4'd15));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        rst_n = 1'b0; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0; din = 4'd0;
        c_rst_n = 1'b0; c_en = 1'b0;
        ea = 4'd0; eb = 4'd0;

        // Reset state
        tick("R3");
        tick("R2");
        drive(1, 1, 0, 0, 4'd0);
        tick("R5");

        // Preset every code, then two counting edges
        for (int c = 0; c < 16; c++) begin
            drive(1, 0, 0, 0, 4'(c));
            tick("R4");
            drive(1, 1, 0, 1, 4'(c));
            #1;
            check("R7", "tc_a after preset", int'(tc_a), int'(c == 9));
            check("R6", "tc_b after preset", int'(tc_b), int'(c == 15));
            drive(1, 1, 1, 1, 4'(c));
            tick("R8");
            tick("R1");
            if (c >= 10) check("R8", "recovered within two counts", int'(q_a <= 4'd9), 1);
        end

        // Long run: several wraps in both moduli
        drive(1, 0, 0, 0, 4'd0);
        tick("R4");
        drive(1, 1, 1, 1, 4'd0);
        repeat (40) tick("R1");

        // Priority sweep over clear, load and both enables
        for (int m = 0; m < 16; m++) begin
            string rq;
            drive(1, 0, 0, 0, 4'd5);
            tick("R4");
            drive(m[3], m[2], m[1], m[0], 4'd12);
            if (!m[3])               rq = "R3";
            else if (!m[2])          rq = "R4";
            else if (m[1] && m[0])   rq = "R1";
            else                     rq = "R5";
            tick(rq);
            drive(1, 1, 0, 0, 4'd0);
        end

        // Terminal count follows the trickle enable within the cycle
        drive(1, 0, 0, 0, 4'd9);
        tick("R4");
        drive(1, 1, 0, 0, 4'd9);
        #1;
        check("R6", "tc_a trickle low", int'(tc_a), 0);
        en_trk = 1'b1;
        #1;
        check("R6", "tc_a trickle high, parallel low", int'(tc_a), 1);
        load_n = 1'b0;
        #1;
        check("R6", "tc_a with load low", int'(tc_a), 1);
        load_n = 1'b1;
        drive(1, 0, 0, 0, 4'd15);
        tick("R4");
        drive(1, 1, 0, 1, 4'd15);
        #1;
        check("R6", "tc_b at 15", int'(tc_b), 1);
        check("R7", "tc_a at 15", int'(tc_a), 0);

        // Immediate versus edge-sampled clear
        drive(1, 0, 0, 0, 4'd7);
        tick("R4");
        drive(1, 1, 0, 0, 4'd7);
        #2;
        rst_n = 1'b0;
        #1;
        check("R2", "q_b cleared without edge", int'(q_b), 0);
        check("R3", "q_a kept until edge", int'(q_a), 7);
        eb = 4'd0;
        tick("R3");
        drive(1, 1, 0, 0, 4'd0);

        // Two-digit chain
        @(negedge clk);
        c_rst_n = 1'b1;
        c_en = 1'b1;
        for (int k = 1; k <= 120; k++) begin
            @(posedge clk);
            #2;
            check("R9", "chain value", int'(q_hi) * 10 + int'(q_lo), k % 100);
            check("R9", "chain carry out", int'(tc_hi), int'((k % 100) == 99));
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule